// File: doc/BRIEF.md
# Daisy-Chain Serial ADC Readback Host

This block is the host side of a chain of serial 18-bit converters that share one conversion strobe and one serial clock. Each device passes its own data out through a shift register and accepts its upstream neighbour's data on a serial input. A single pulse on `start_i` runs one transaction. The host raises the conversion strobe while the serial clock is parked low, which selects chain mode without the busy indicator. It waits a fixed number of clock cycles for the conversion to finish. It then issues 18 × N serial clocks and shifts in the returning bit stream, sampling on each falling edge of its own serial clock.

When the last bit has been taken, the strobe drops. The N recovered words appear together on a wide parallel bus, with a one-cycle valid pulse. Words are packed by chain position. Word 0 is the device wired directly to the host and occupies the lowest 18 bits. Each higher slot holds a device further up the chain. The serial clock rate comes from an internal divider of the system clock.

Top module: `chain_adc_host`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cnv_o`, `sck_o`, `busy_o` and `res_valid_o` are all low.
- R2: A `start_i` seen high while idle makes `cnv_o` and `busy_o` go high on the next cycle while `sck_o` stays low. The first `sck_o` rising edge follows the `cnv_o` rising edge by exactly CONV_CYCLES + SCK_HALF clock cycles.
- R3: `cnv_o` stays high without a gap from its rising edge until the cycle in which `res_valid_o` is asserted. `sck_o` is never high while `cnv_o` is low.
- R4: Each transaction produces exactly WORD_W × NUM_DEV `sck_o` rising edges. Each high and each low phase lasts SCK_HALF clock cycles, so `res_valid_o` rises CONV_CYCLES + 2 × SCK_HALF × WORD_W × NUM_DEV cycles after `cnv_o` rises. `sck_o` idles low.
- R5: `sdi_i` is sampled at the clock edge on which `sck_o` falls. The first bit taken is the one already on the line before the first serial clock edge, and each word is received most significant bit first.
- R6: Result slot k, bits [k×WORD_W +: WORD_W] of `res_data_o`, holds the (k+1)-th WORD_W-bit group received. Slot 0 is the device nearest the host.
- R7: `res_valid_o` is high for exactly one cycle, on the same cycle that `cnv_o` returns low. `res_data_o` keeps its value until the next valid pulse.
- R8: `start_i` is ignored while a transaction runs. No second strobe follows a transaction unless a new start arrives after it.
- R9: `busy_o` is high in exactly the cycles in which `cnv_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readback |
| sdi_i | input | 1 | Serial data from the nearest chained device |
| cnv_o | output | 1 | Conversion strobe / chain enable |
| sck_o | output | 1 | Serial clock to the chain, idles low |
| busy_o | output | 1 | Transaction in progress |
| res_valid_o | output | 1 | One-cycle pulse when results are updated |
| res_data_o | output | WORD_W × NUM_DEV | Packed results, slot 0 = nearest device |

## Verification
On every cycle, the bound checker watches the strobe and clock relationship. It checks that the serial clock never runs without the strobe, that the clock idles low when not busy, and that busy tracks the strobe. It also checks that the valid pulse is one cycle long and coincides with the strobe's fall. It counts serial clock rising edges in each transaction, and checks that the clock never starts before the conversion wait has elapsed.

The bench's scenarios must show that data is recovered correctly. A behavioural model of three chained shift registers is used. The scenarios show that the correct word lands in each slot in chain order, that the first bit before any edge is kept, and that MSB-first order holds. They also check the exact cycle counts of the wait and the readback, that results are held between pulses, and that a start issued mid-transaction has no effect.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_READ = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chain_sck_gen.sv
// Serial clock divider: each phase lasts HALF clk cycles while run_i is high.
module chain_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] PH_END = CW'(HALF - 1);

  logic [CW-1:0] ph_cnt;
  logic          sck_q;
  logic          ph_done;

  assign ph_done = run_i && (ph_cnt == PH_END);
  assign fall_o  = ph_done && sck_q;
  assign sck_o   = sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      ph_cnt <= '0;
      sck_q  <= 1'b0;
    end else if (ph_done) begin
      ph_cnt <= '0;
      sck_q  <= ~sck_q;
    end else begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chain_seq.sv
// Transaction sequencer: strobe, conversion wait, bit counting.
module chain_seq
  import chain_adc_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int NUM_DEV     = 3,
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic fall_i,
  output logic run_o,
  output logic cap_o,
  output logic last_o,
  output logic cnv_o,
  output logic busy_o
);
  localparam int TOTAL = WORD_W * NUM_DEV;
  localparam int BW    = $clog2(TOTAL + 1);
  localparam int WW    = $clog2(CONV_CYCLES + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);
  localparam logic [WW-1:0] WAIT_END = WW'(CONV_CYCLES - 1);

  seq_state_e    state;
  logic [BW-1:0] bit_cnt;
  logic [WW-1:0] wait_cnt;

  assign run_o  = (state == SEQ_READ);
  assign cap_o  = run_o && fall_i;
  assign last_o = cap_o && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      bit_cnt  <= '0;
      wait_cnt <= '0;
      cnv_o    <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          bit_cnt  <= '0;
          wait_cnt <= '0;
          if (start_i) begin
            state  <= SEQ_CONV;
            cnv_o  <= 1'b1;
            busy_o <= 1'b1;
          end
        end
        SEQ_CONV: begin
          if (wait_cnt == WAIT_END) state <= SEQ_READ;
          else                      wait_cnt <= wait_cnt + 1'b1;
        end
        SEQ_READ: begin
          if (cap_o) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last_o) begin
              state  <= SEQ_IDLE;
              cnv_o  <= 1'b0;
              busy_o <= 1'b0;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_shift_asm.sv
// Captures the serial stream and unpacks it into per-device slots.
module chain_shift_asm #(
  parameter int WORD_W  = 18,
  parameter int NUM_DEV = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_i,
  input  logic                      last_i,
  input  logic                      sdi_i,
  output logic [WORD_W*NUM_DEV-1:0] data_o,
  output logic                      valid_o
);
  localparam int TOTAL = WORD_W * NUM_DEV;

  logic [TOTAL-1:0] shreg;
  logic [TOTAL-1:0] next_sh;
  logic [TOTAL-1:0] reordered;

  assign next_sh = {shreg[TOTAL-2:0], sdi_i};

  // Earliest bits land highest in the shift register; slot 0 must be lowest.
  for (genvar k = 0; k < NUM_DEV; k++) begin : g_slot
    assign reordered[k*WORD_W +: WORD_W] = next_sh[(NUM_DEV-1-k)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i && last_i;
      if (cap_i) begin
        shreg <= next_sh;
        if (last_i) data_o <= reordered;
      end
    end
  end
endmodule

// File: rtl/chain_adc_host.sv
module chain_adc_host #(
  parameter int WORD_W      = 18,
  parameter int NUM_DEV     = 3,
  parameter int SCK_HALF    = 2,
  parameter int CONV_CYCLES = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      sdi_i,
  output logic                      cnv_o,
  output logic                      sck_o,
  output logic                      busy_o,
  output logic                      res_valid_o,
  output logic [WORD_W*NUM_DEV-1:0] res_data_o
);
  logic run, fall, cap, last;

  chain_seq #(
    .WORD_W(WORD_W), .NUM_DEV(NUM_DEV), .CONV_CYCLES(CONV_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .fall_i(fall),
    .run_o(run), .cap_o(cap), .last_o(last), .cnv_o(cnv_o), .busy_o(busy_o)
  );

  chain_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst(rst), .run_i(run), .sck_o(sck_o), .fall_o(fall)
  );

  chain_shift_asm #(.WORD_W(WORD_W), .NUM_DEV(NUM_DEV)) u_asm (
    .clk(clk), .rst(rst), .cap_i(cap), .last_i(last), .sdi_i(sdi_i),
    .data_o(res_data_o), .valid_o(res_valid_o)
  );
endmodule

// File: rtl/chain_adc_host_chk.sv
module chain_adc_host_chk #(
  parameter int WORD_W      = 18,
  parameter int NUM_DEV     = 3,
  parameter int CONV_CYCLES = 20
) (
  input logic clk,
  input logic rst,
  input logic cnv_o,
  input logic sck_o,
  input logic busy_o,
  input logic res_valid_o
);
  localparam int TOTAL = WORD_W * NUM_DEV;
  localparam int RW    = $clog2(TOTAL + 1) + 1;
  localparam int CWID  = $clog2(CONV_CYCLES + 1) + 1;

  logic [RW-1:0]   rise_cnt;
  logic [CWID-1:0] hi_cyc;
  logic            sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      hi_cyc   <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_o;
      if (!cnv_o && !res_valid_o) rise_cnt <= '0;
      else if (sck_o && !sck_prev) rise_cnt <= rise_cnt + 1'b1;
      if (!cnv_o) hi_cyc <= '0;
      else if (hi_cyc != '1) hi_cyc <= hi_cyc + 1'b1;
    end
  end

  // R3
  sck_needs_cnv_chk: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> cnv_o);
  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sck_o);
  // R9
  busy_tracks_cnv_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o == cnv_o);
  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o);
  // R7
  valid_at_cnv_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_o) |-> res_valid_o);
  // R4
  rise_total_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (rise_cnt == RW'(TOTAL)));
  // R2
  conv_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_o && !sck_prev && rise_cnt == '0) |-> (hi_cyc >= CWID'(CONV_CYCLES)));
endmodule

bind chain_adc_host chain_adc_host_chk #(
  .WORD_W(WORD_W), .NUM_DEV(NUM_DEV), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cnv_o(cnv_o), .sck_o(sck_o),
  .busy_o(busy_o), .res_valid_o(res_valid_o)
);

// File: tb/chain_adc_host_tb.sv
module chain_adc_host_tb;
  localparam int W     = 18;
  localparam int NDEV  = 3;
  localparam int HALF  = 2;
  localparam int CONV  = 20;
  localparam int TOTAL = W * NDEV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sdi_i;
  logic cnv_o, sck_o, busy_o, res_valid_o;
  logic [W*NDEV-1:0] res_data_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  chain_adc_host #(
    .WORD_W(W), .NUM_DEV(NDEV), .SCK_HALF(HALF), .CONV_CYCLES(CONV)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sdi_i(sdi_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .busy_o(busy_o),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o)
  );

  // Behavioural chain: each device shifts on the serial clock's falling edge.
  logic [W-1:0] dev_sr   [NDEV];
  logic [W-1:0] dev_word [NDEV];
  logic         load_ev = 1'b0;

  always @(negedge sck_o or posedge load_ev) begin
    if (load_ev) begin
      for (int k = 0; k < NDEV; k++) dev_sr[k] <= dev_word[k];
    end else begin
      for (int k = 0; k < NDEV; k++)
        dev_sr[k] <= {dev_sr[k][W-2:0], (k == NDEV-1) ? 1'b0 : dev_sr[k+1][W-1]};
    end
  end

  assign sdi_i = cnv_o ? dev_sr[0][W-1] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!cnv_o && !sck_o, "R1 cnv/sck in reset", {cnv_o, sck_o}, 0);
    check(!busy_o && !res_valid_o, "R1 busy/valid in reset", {busy_o, res_valid_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!cnv_o && !sck_o && !busy_o && !res_valid_o, "R1 after reset",
          {cnv_o, sck_o, busy_o, res_valid_o}, 0);
  endtask

  task automatic run_txn(input logic [W-1:0] w0, input logic [W-1:0] w1,
                         input logic [W-1:0] w2, input bit poke);
    int t, first_rise, rises, gaps, busy_bad, vt;
    logic prev_sck;
    dev_word[0] = w0; dev_word[1] = w1; dev_word[2] = w2;
    load_ev = 1'b1;
    @(negedge clk);
    load_ev = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cnv_o && busy_o && !sck_o, "R2 strobe up, clock low",
          {cnv_o, busy_o, sck_o}, 3'b110);
    t = 0; first_rise = -1; rises = 0; gaps = 0; busy_bad = 0; vt = -1;
    prev_sck = sck_o;
    while (vt < 0 && t < 2000) begin
      @(negedge clk);
      t++;
      if (poke) start_i = (t == 100);
      if (sck_o && !prev_sck) begin
        rises++;
        if (first_rise < 0) first_rise = t;
      end
      prev_sck = sck_o;
      if (busy_o != cnv_o) busy_bad++;
      if (res_valid_o) vt = t;
      else if (!cnv_o) gaps++;
    end
    start_i = 1'b0;
    check(first_rise == CONV + HALF, "R2 first sck rise delay", first_rise, CONV + HALF);
    check(vt == CONV + 2*HALF*TOTAL, "R4 readback length", vt, CONV + 2*HALF*TOTAL);
    check(rises == TOTAL, "R4 sck rising edges", rises, TOTAL);
    check(gaps == 0, "R3 strobe gap before valid", gaps, 0);
    check(busy_bad == 0, "R9 busy vs strobe", busy_bad, 0);
    check(!cnv_o, "R7 strobe low with valid", cnv_o, 0);
    check(res_data_o[0 +: W] == w0, "R6 slot 0", res_data_o[0 +: W], w0);
    check(res_data_o[W +: W] == w1, "R6 slot 1", res_data_o[W +: W], w1);
    check(res_data_o[2*W +: W] == w2, "R6 slot 2", res_data_o[2*W +: W], w2);
    @(negedge clk);
    check(!res_valid_o, "R7 valid one cycle", res_valid_o, 0);
    begin
      int extra = 0;
      repeat (15) begin
        @(negedge clk);
        if (cnv_o || busy_o) extra++;
      end
      check(extra == 0, "R8 no strobe without new start", extra, 0);
    end
  endtask

  task automatic test_basic();
    run_txn(18'h2A5C3, 18'h1F00E, 18'h35A71, 1'b0);
  endtask

  task automatic test_edges();
    // R5: MSB-only and LSB-only words prove bit order and first-bit capture.
    run_txn(18'h20000, 18'h00001, 18'h3FFFF, 1'b0);
    check(res_data_o[W-1] == 1'b1, "R5 first bit is MSB of slot 0", res_data_o[W-1], 1);
    run_txn(18'h00001, 18'h20000, 18'h00000, 1'b0);
    check(res_data_o[0 +: W] == 18'h00001, "R5 LSB of slot 0", res_data_o[0 +: W], 1);
  endtask

  task automatic test_busy_start();
    run_txn(18'h15555, 18'h2AAAA, 18'h0F0F0, 1'b1);
  endtask

  task automatic test_hold();
    logic [W*NDEV-1:0] snap;
    snap = res_data_o;
    repeat (30) @(negedge clk);
    check(res_data_o == snap, "R7 results held", res_data_o[63:0], snap[63:0]);
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_edges();
    test_busy_start();
    test_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule